// File: doc/BRIEF.md
# Reed-Solomon 12-bit Symbol Error Applier

This block takes the output of a Reed-Solomon decoder: a short list of symbol positions, each paired with a 12-bit error value. It folds those values into a page buffer held in a byte-wide, single-port RAM. The buffer stores a 2048-byte data area followed directly by the spare bytes. Each 12-bit symbol spans a byte and a half, so every correction touches one or two bytes. Each byte is updated by a read, an XOR and a write.

Pairs arrive one at a time over a valid/ready handshake, and the last pair of a page is marked. After the final pair has been handled, the block raises a one-cycle done pulse. At that point it reports how many symbols it corrected and whether the page turned out to be uncorrectable. Computing the syndromes and solving for the error locations happen upstream of this block.

Top module: `rs_sym_fixer`

## Requirements
- R1: After reset `pair_ready_o` is 1, while `done_o`, `ram_en_o`, `count_o` and `fail_o` are all 0.
- R2: For an odd position p, let b = floor(3p/2). Pattern bits 11:4 are XORed into byte b, and bits 3:0 are XORed into the high nibble (bits 7:4) of byte b+1.
- R3: For an even, nonzero position p, let b = 3p/2. Pattern bits 11:8 are XORed into the low nibble (bits 3:0) of byte b-1, and bits 7:0 are XORed into byte b.
- R4: Position 0 carries 8 data bits. A pattern no greater than 0xFF is XORed into byte 0. A larger pattern marks the page failed and leaves the buffer untouched.
- R5: Position 1365 straddles the area boundary. Bits 11:4 go to byte 2047, the last data byte. Bits 3:0 go to the high nibble of byte 2048, which is the first spare byte.
- R6: Positions 1366 to 1374 land in the spare area (bytes 2048 and up) under the same odd and even rules. Every RAM address stays below 2112.
- R7: A position above 1374 marks the page failed and is not written.
- R8: `count_o` reports the number of symbols applied, at most 4. A fifth applied pair in one page sets `fail_o` and is not written.
- R9: Once a page has failed, its remaining pairs are still accepted but cause no RAM access.
- R10: `pair_ready_o` is high only when the block is idle, and never while the RAM is being accessed. `done_o` lasts exactly one cycle and comes after the last pair is finished. `count_o` and `fail_o` hold their values until the first pair of the next page is accepted.
- R11: Every byte update is a read cycle (`ram_en_o`=1, `ram_we_o`=0) followed in the next cycle by a write to the same address. A one-byte correction therefore uses 2 RAM cycles, and a two-byte correction uses 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pair_valid_i | input | 1 | An error pair is offered |
| pair_ready_o | output | 1 | The block accepts a pair this cycle |
| pair_pos_i | input | 11 | Symbol position |
| pair_pat_i | input | 12 | Error value to XOR in |
| pair_last_i | input | 1 | This pair is the last one of the page |
| ram_en_o | output | 1 | RAM access enable |
| ram_we_o | output | 1 | RAM write (1) or read (0) |
| ram_addr_o | output | 12 | RAM byte address |
| ram_wdata_o | output | 8 | RAM write data |
| ram_rdata_i | input | 8 | RAM read data, valid one cycle after the read |
| done_o | output | 1 | Page finished, one-cycle pulse |
| count_o | output | 3 | Number of symbols corrected |
| fail_o | output | 1 | Page is uncorrectable |

## Verification
The bench aims at the nibble split for both parities of the position. A swapped split would corrupt the wrong half of a neighbouring byte. It drives position 0 with patterns just inside and just outside 8 bits. A design that ignores the top bits would silently damage byte 0. It also covers the boundary symbol 1365, the last legal position 1374 and the first illegal one, 1375. An off-by-one range check shows up there as a write past the buffer or a missing failure. Finally, the bench checks the fifth-pair limit and the skipping of pairs after a failure by comparing the whole buffer and counting RAM cycles. A design that keeps applying pairs after failing would change bytes that must stay intact.

// File: rtl/rs_fix_pkg.sv
package rs_fix_pkg;
  localparam int SYM_W = 12;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_A,
    ST_WR_A,
    ST_RD_B,
    ST_WR_B,
    ST_DONE
  } fix_state_e;
endpackage

// File: rtl/rs_sym_map.sv
module rs_sym_map
  import rs_fix_pkg::*;
#(
  parameter int POS_W   = 11,
  parameter int AW      = 12,
  parameter int MAX_POS = 1374
) (
  input  logic [POS_W-1:0] pos_i,
  input  logic [SYM_W-1:0] pat_i,
  output logic [AW-1:0]    addr_a_o,
  output logic [7:0]       mask_a_o,
  output logic [7:0]       mask_b_o,
  output logic             two_o,
  output logic             bad_o
);
  localparam int TW = POS_W + 2;

  logic [TW-1:0] triple;
  logic [TW-2:0] half;

  assign triple = TW'(pos_i) + TW'({pos_i, 1'b0});
  assign half   = triple[TW-1:1];

  always_comb begin
    bad_o = (pos_i > POS_W'(MAX_POS));
    if (pos_i[0]) begin
      addr_a_o = AW'(half);
      mask_a_o = pat_i[11:4];
      mask_b_o = {pat_i[3:0], 4'h0};
      two_o    = 1'b1;
    end else if (pos_i == '0) begin
      // truncated leading symbol: only 8 bits exist in the buffer
      addr_a_o = '0;
      mask_a_o = pat_i[7:0];
      mask_b_o = '0;
      two_o    = 1'b0;
      bad_o    = |pat_i[11:8];
    end else begin
      addr_a_o = AW'(half - (TW-1)'(1));
      mask_a_o = {4'h0, pat_i[11:8]};
      mask_b_o = pat_i[7:0];
      two_o    = 1'b1;
    end
  end
endmodule

// File: rtl/rs_rmw_seq.sv
module rs_rmw_seq
  import rs_fix_pkg::*;
#(
  parameter int AW      = 12,
  parameter int MAX_ERR = 4,
  parameter int CW      = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          pair_valid_i,
  input  logic          pair_last_i,
  input  logic [AW-1:0] addr_a_i,
  input  logic [7:0]    mask_a_i,
  input  logic [7:0]    mask_b_i,
  input  logic          two_i,
  input  logic          bad_i,
  output logic          pair_ready_o,
  output logic          ram_en_o,
  output logic          ram_we_o,
  output logic [AW-1:0] ram_addr_o,
  output logic [7:0]    ram_wdata_o,
  input  logic [7:0]    ram_rdata_i,
  output logic          done_o,
  output logic [CW-1:0] count_o,
  output logic          fail_o
);
  fix_state_e    state_q, state_d;
  logic [AW-1:0] addr_q;
  logic [7:0]    mask_a_q, mask_b_q;
  logic          two_q, last_q, fresh_q, fail_q;
  logic [CW-1:0] cnt_q;

  logic          accept, full, reject, fail_base;
  logic [CW-1:0] cnt_base;

  assign accept    = pair_valid_i && (state_q == ST_IDLE);
  assign cnt_base  = fresh_q ? '0 : cnt_q;
  assign fail_base = fresh_q ? 1'b0 : fail_q;
  assign full      = (cnt_base == CW'(MAX_ERR));
  assign reject    = bad_i || full || fail_base;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (accept) state_d = reject ? (pair_last_i ? ST_DONE : ST_IDLE) : ST_RD_A;
      ST_RD_A: state_d = ST_WR_A;
      ST_WR_A: state_d = two_q ? ST_RD_B : (last_q ? ST_DONE : ST_IDLE);
      ST_RD_B: state_d = ST_WR_B;
      ST_WR_B: state_d = last_q ? ST_DONE : ST_IDLE;
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      addr_q   <= '0;
      mask_a_q <= '0;
      mask_b_q <= '0;
      two_q    <= 1'b0;
      last_q   <= 1'b0;
      fresh_q  <= 1'b1;
      fail_q   <= 1'b0;
      cnt_q    <= '0;
    end else begin
      state_q <= state_d;
      if (accept) begin
        addr_q   <= addr_a_i;
        mask_a_q <= mask_a_i;
        mask_b_q <= mask_b_i;
        two_q    <= two_i;
        last_q   <= pair_last_i;
        fresh_q  <= 1'b0;
        fail_q   <= fail_base | reject;
        cnt_q    <= reject ? cnt_base : cnt_base + CW'(1);
      end
      if (state_q == ST_DONE) fresh_q <= 1'b1;
    end
  end

  logic second;
  assign second       = (state_q == ST_RD_B) || (state_q == ST_WR_B);
  assign pair_ready_o = (state_q == ST_IDLE);
  assign ram_en_o     = (state_q == ST_RD_A) || (state_q == ST_WR_A) || second;
  assign ram_we_o     = (state_q == ST_WR_A) || (state_q == ST_WR_B);
  assign ram_addr_o   = second ? addr_q + AW'(1) : addr_q;
  assign ram_wdata_o  = ram_rdata_i ^ (second ? mask_b_q : mask_a_q);
  assign done_o       = (state_q == ST_DONE);
  assign count_o      = cnt_q;
  assign fail_o       = fail_q;
endmodule

// File: rtl/rs_sym_fixer.sv
module rs_sym_fixer
  import rs_fix_pkg::*;
#(
  parameter int DATA_BYTES  = 2048,
  parameter int SPARE_BYTES = 64,
  parameter int POS_W       = 11,
  parameter int MAX_POS     = 1374,
  parameter int MAX_ERR     = 4,
  localparam int BUF_BYTES  = DATA_BYTES + SPARE_BYTES,
  localparam int AW         = $clog2(BUF_BYTES),
  localparam int CW         = $clog2(MAX_ERR + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pair_valid_i,
  output logic             pair_ready_o,
  input  logic [POS_W-1:0] pair_pos_i,
  input  logic [SYM_W-1:0] pair_pat_i,
  input  logic             pair_last_i,
  output logic             ram_en_o,
  output logic             ram_we_o,
  output logic [AW-1:0]    ram_addr_o,
  output logic [7:0]       ram_wdata_o,
  input  logic [7:0]       ram_rdata_i,
  output logic             done_o,
  output logic [CW-1:0]    count_o,
  output logic             fail_o
);
  logic [AW-1:0] addr_a;
  logic [7:0]    mask_a, mask_b;
  logic          two, bad;

  rs_sym_map #(.POS_W(POS_W), .AW(AW), .MAX_POS(MAX_POS)) u_map (
    .pos_i    (pair_pos_i),
    .pat_i    (pair_pat_i),
    .addr_a_o (addr_a),
    .mask_a_o (mask_a),
    .mask_b_o (mask_b),
    .two_o    (two),
    .bad_o    (bad)
  );

  rs_rmw_seq #(.AW(AW), .MAX_ERR(MAX_ERR), .CW(CW)) u_seq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .pair_valid_i (pair_valid_i),
    .pair_last_i  (pair_last_i),
    .addr_a_i     (addr_a),
    .mask_a_i     (mask_a),
    .mask_b_i     (mask_b),
    .two_i        (two),
    .bad_i        (bad),
    .pair_ready_o (pair_ready_o),
    .ram_en_o     (ram_en_o),
    .ram_we_o     (ram_we_o),
    .ram_addr_o   (ram_addr_o),
    .ram_wdata_o  (ram_wdata_o),
    .ram_rdata_i  (ram_rdata_i),
    .done_o       (done_o),
    .count_o      (count_o),
    .fail_o       (fail_o)
  );
endmodule

// File: rtl/rs_fix_chk.sv
module rs_fix_chk #(
  parameter int AW        = 12,
  parameter int CW        = 3,
  parameter int MAX_ERR   = 4,
  parameter int BUF_BYTES = 2112
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          pair_ready_o,
  input logic          ram_en_o,
  input logic          ram_we_o,
  input logic [AW-1:0] ram_addr_o,
  input logic          done_o,
  input logic [CW-1:0] count_o
);
  p_ready_excl_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pair_ready_o |-> !ram_en_o);

  p_done_pulse_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_rd_then_wr_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ram_en_o && !ram_we_o) |=> (ram_en_o && ram_we_o && ram_addr_o == $past(ram_addr_o)));

  p_wr_after_rd_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ram_we_o |-> ram_en_o && $past(ram_en_o && !ram_we_o));

  p_count_cap_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_o <= CW'(MAX_ERR));

  p_addr_range_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ram_en_o |-> (32'(ram_addr_o) < BUF_BYTES));
endmodule

bind rs_sym_fixer rs_fix_chk #(.AW(AW), .CW(CW), .MAX_ERR(MAX_ERR), .BUF_BYTES(BUF_BYTES)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .pair_ready_o (pair_ready_o),
  .ram_en_o     (ram_en_o),
  .ram_we_o     (ram_we_o),
  .ram_addr_o   (ram_addr_o),
  .done_o       (done_o),
  .count_o      (count_o)
);

// File: tb/rs_sym_fixer_test.sv
module rs_sym_fixer_test;
  localparam int NB = 2112;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        pair_valid_i = 1'b0;
  logic        pair_ready_o;
  logic [10:0] pair_pos_i = '0;
  logic [11:0] pair_pat_i = '0;
  logic        pair_last_i = 1'b0;
  logic        ram_en_o, ram_we_o;
  logic [11:0] ram_addr_o;
  logic [7:0]  ram_wdata_o;
  logic [7:0]  ram_rdata_i = '0;
  logic        done_o;
  logic [2:0]  count_o;
  logic        fail_o;

  logic [7:0] mem [NB];
  logic [7:0] exp_mem [NB];
  int nchk = 0, nfail = 0, en_cnt = 0, cyc = 0;

  always #10 clk = ~clk;

  rs_sym_fixer uut (
    .clk_i(clk), .rst_ni(rst_ni),
    .pair_valid_i(pair_valid_i), .pair_ready_o(pair_ready_o),
    .pair_pos_i(pair_pos_i), .pair_pat_i(pair_pat_i), .pair_last_i(pair_last_i),
    .ram_en_o(ram_en_o), .ram_we_o(ram_we_o), .ram_addr_o(ram_addr_o),
    .ram_wdata_o(ram_wdata_o), .ram_rdata_i(ram_rdata_i),
    .done_o(done_o), .count_o(count_o), .fail_o(fail_o)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (ram_en_o) begin
      en_cnt <= en_cnt + 1;
      if (ram_we_o) mem[ram_addr_o] <= ram_wdata_o;
      else ram_rdata_i <= mem[ram_addr_o];
    end
  end

  always @(posedge clk) begin
    if (cyc > 100000) begin
      nfail++;
      $display("FAIL watchdog: run hung, actual cycles %0d expected < 100000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic init_buf();
    for (int a = 0; a < NB; a++) begin
      mem[a] = 8'(a * 37 + 11);
      exp_mem[a] = mem[a];
    end
  endtask

  // expected effect derived from the position rules
  task automatic model(input int pos, input int pat);
    int b;
    b = (3 * pos) / 2;
    if (pos == 0) exp_mem[0] ^= 8'(pat);
    else if (pos % 2 == 1) begin
      exp_mem[b]   ^= 8'(pat >> 4);
      exp_mem[b+1] ^= 8'((pat & 15) << 4);
    end else begin
      exp_mem[b-1] ^= 8'((pat >> 8) & 15);
      exp_mem[b]   ^= 8'(pat);
    end
  endtask

  task automatic send(input int pos, input int pat, input bit last);
    @(negedge clk);
    pair_valid_i = 1'b1;
    pair_pos_i   = 11'(pos);
    pair_pat_i   = 12'(pat);
    pair_last_i  = last;
    while (!pair_ready_o) @(negedge clk);
    @(negedge clk);
    pair_valid_i = 1'b0;
  endtask

  task automatic finish_page(input string req, input int cnt, input int fl, input int ens);
    int bad;
    while (!done_o) @(negedge clk);
    chk({req, " count"}, int'(count_o), cnt);
    chk({req, " fail"}, int'(fail_o), fl);
    chk({req, " ram cycles"}, en_cnt, ens);
    bad = 0;
    for (int a = 0; a < NB; a++) if (mem[a] !== exp_mem[a]) bad++;
    chk({req, " buffer mismatches"}, bad, 0);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R1 ready", int'(pair_ready_o), 1);
    chk("R1 done", int'(done_o), 0);
    chk("R1 ram_en", int'(ram_en_o), 0);
    chk("R1 count", int'(count_o), 0);
    chk("R1 fail", int'(fail_o), 0);
  endtask

  task automatic t_odd();
    init_buf(); en_cnt = 0;
    model(5, 'hA5C);
    send(5, 'hA5C, 1);
    finish_page("R2 odd p=5", 1, 0, 4);
  endtask

  task automatic t_even_multi();
    init_buf(); en_cnt = 0;
    model(10, 'h3E7); model(3, 'hF0F); model(1364, 'h9B2);
    send(10, 'h3E7, 0); send(3, 'hF0F, 0); send(1364, 'h9B2, 1);
    finish_page("R3 even multi", 3, 0, 12);
  endtask

  task automatic t_sym0();
    init_buf(); en_cnt = 0;
    model(0, 'h0A5);
    send(0, 'h0A5, 1);
    finish_page("R4 sym0 ok", 1, 0, 2);
    init_buf(); en_cnt = 0;
    send(0, 'h1A5, 1);
    finish_page("R4 sym0 wide", 0, 1, 0);
  endtask

  task automatic t_boundary();
    init_buf(); en_cnt = 0;
    model(1365, 'hABC);
    send(1365, 'hABC, 1);
    finish_page("R5 p=1365", 1, 0, 4);
  endtask

  task automatic t_spare();
    init_buf(); en_cnt = 0;
    model(1367, 'h5A1); model(1374, 'hC3D);
    send(1367, 'h5A1, 0); send(1374, 'hC3D, 1);
    finish_page("R6 spare", 2, 0, 8);
  endtask

  task automatic t_range();
    init_buf(); en_cnt = 0;
    send(1375, 'h123, 1);
    finish_page("R7 p=1375", 0, 1, 0);
  endtask

  task automatic t_limit();
    init_buf(); en_cnt = 0;
    model(1, 'h111); model(2, 'h222); model(3, 'h333); model(4, 'h444);
    send(1, 'h111, 0); send(2, 'h222, 0); send(3, 'h333, 0); send(4, 'h444, 0);
    send(9, 'h999, 1);
    finish_page("R8 fifth pair", 4, 1, 16);
  endtask

  task automatic t_after_fail();
    init_buf(); en_cnt = 0;
    send(2000, 'h777, 0); send(7, 'h777, 1);
    finish_page("R9 after fail", 0, 1, 0);
  endtask

  task automatic t_hold();
    init_buf(); en_cnt = 0;
    model(21, 'h456);
    send(21, 'h456, 1);
    finish_page("R10 pulse page", 1, 0, 4);
    @(negedge clk);
    chk("R10 done one cycle", int'(done_o), 0);
    repeat (3) @(negedge clk);
    chk("R10 count held", int'(count_o), 1);
    chk("R10 ready idle", int'(pair_ready_o), 1);
  endtask

  initial begin
    init_buf();
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    t_reset();
    t_odd();
    t_even_multi();
    t_sym0();
    t_boundary();
    t_spare();
    t_range();
    t_limit();
    t_after_fail();
    t_hold();
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule